// File: doc/BRIEF.md
# Tiny Binary-Image CNN Classifier

This block classifies one 8x8 black-and-white image into one of two classes. A caller places the 64 pixel bits on a single input vector and pulses a start strobe. The engine then runs four layers in a fixed sequence:

- it turns each pixel into an 8-bit signed value;
- it convolves the result with four fixed 3x3 kernels;
- it keeps the maximum of each 2x2 tile;
- it scores the pooled features against two fixed weight sets.

When the sequence ends, the engine raises a done pulse together with the index of the winning class.

A small controller walks the layers one at a time. For each layer it drives a clock-enable output and a power-enable output, and only the layer that is working has its pair raised. Logic outside the block can use these signals to gate idle layers. Inside the block, the same clock-enable bits act as register load enables, so an idle layer holds its results.

Each layer takes one cycle. A new image can be started on any cycle in which the engine is idle.

Top module: `tiny_cnn_classifier`

## Requirements
- R1: The image is sampled only on a clock edge where `start` is high and the engine is idle. A `start` or `img` change at any other time has no effect on the result.
- R2: After an accepted start the engine visits quantize, convolve, pool, score and finish, one cycle each and in that order. `done` is high on the fifth cycle after the accepting edge.
- R3: Quantization maps pixel bit `img[r*8+c]` (row r, column c) to signed 127 when the bit is 1 and to 0 when it is 0.
- R4: Convolution is valid-only and produces a 6x6 map for each of 4 filters. The tap for filter f at kernel row kr and kernel column kc is `((f*9+kr*3+kc)*5+f) mod 4 - 1`. Sums are kept in 20-bit signed precision and then saturated to the range -128..127.
- R5: Pooling takes the signed maximum of each non-overlapping 2x2 tile, which gives 3x3 values per filter. Pooled feature i is numbered `f*9+pr*3+pc`, for 36 features in all.
- R6: The score of class k is the sum, over the features, of feature i times `(i*5+k*7) mod 3 - 1`. `class_idx` becomes 1 only when score 1 is strictly greater than score 0, so a tie gives 0.
- R7: `clk_en` and `pwr_en` use bit 0 for quantize, bit 1 for convolve, bit 2 for pool and bit 3 for score. Exactly that bit is high while its layer is active, and both buses are zero in idle and finish.
- R8: `done` is high for exactly one cycle, and the engine is idle on the cycle after it.
- R9: A layer's registers change only on a cycle in which its clock enable is high. In particular, `class_idx` holds its value from one result until the score cycle of the next run.
- R10: While `rst_n` is low at a clock edge, the engine returns to idle with `done` low, both enable buses zero and `class_idx` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Start strobe, honoured only while idle |
| img | input | 64 | Binary image; bit r*8+c is row r, column c |
| clk_en | output | 4 | Per-layer clock enables (quantize, convolve, pool, score) |
| pwr_en | output | 4 | Per-layer power enables, same bit order |
| done | output | 1 | One-cycle result strobe |
| class_idx | output | 1 | Winning class index |

## Verification
The embedded assertions check the following on every cycle:

- at most one layer enable is high;
- `done` never lasts two cycles;
- the score cycle is always followed by finish;
- a busy engine never restarts quantization;
- idle pooling and scoring registers do not change.

The arithmetic can only be shown by the bench's scenarios. These cover the quantization values, kernel taps, saturation, signed max pooling, scoring and the tie rule, compared against an independent reference over many images. The scenarios also show that a late `start` or `img` change is ignored and that a reset in mid-run leaves the engine idle.

// File: rtl/tcnn_pkg.sv
// Package: shared sizes, controller state type and the fixed network constants.
// Assumes a square binary image and a square kernel smaller than the image.
package tcnn_pkg;

    localparam int IMG    = 8;
    localparam int KER    = 3;
    localparam int NFILT  = 4;
    localparam int DW     = 8;
    localparam int ACC_W  = 20;
    localparam int SC_W   = 16;
    localparam int NCLS   = 2;
    localparam int NSTG   = 4;

    localparam int CONV_N = IMG - KER + 1;
    localparam int POOL_N = CONV_N / 2;
    localparam int NPIX   = IMG * IMG;
    localparam int NCONV  = NFILT * CONV_N * CONV_N;
    localparam int NPOOL  = NFILT * POOL_N * POOL_N;
    localparam int CLS_W  = (NCLS > 1) ? $clog2(NCLS) : 1;

    localparam logic [DW-1:0] Q_ONE = DW'((1 << (DW - 1)) - 1);
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((1 << (DW - 1)) - 1);
    localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - ACC_W'(1);

    typedef enum logic [2:0] {
        S_IDLE, S_QUANT, S_CONV, S_POOL, S_FC, S_DONE
    } state_t;

    // Fixed kernel tap in {-1,0,1,2}.
    function automatic logic signed [ACC_W-1:0] conv_w(int f, int kr, int kc);
        int v;
        v = ((f * KER * KER + kr * KER + kc) * 5 + f) % 4 - 1;
        return ACC_W'(v);
    endfunction

    // Fixed scoring weight in {-1,0,1}.
    function automatic logic signed [SC_W-1:0] fc_w(int k, int i);
        int v;
        v = (i * 5 + k * 7) % 3 - 1;
        return SC_W'(v);
    endfunction

    // Clamp a wide sum into the signed pixel range.
    function automatic logic [DW-1:0] sat_px(logic signed [ACC_W-1:0] a);
        if (a > SAT_HI) return DW'(SAT_HI);
        if (a < SAT_LO) return DW'(SAT_LO);
        return DW'(a);
    endfunction

    // Signed maximum of two pixels.
    function automatic logic [DW-1:0] smax(logic [DW-1:0] a, logic [DW-1:0] b);
        return (signed'(a) > signed'(b)) ? a : b;
    endfunction

endpackage

// File: rtl/tcnn_ctrl.sv
// Controller: walks idle -> quantize -> convolve -> pool -> score -> finish.
// Raises one layer's clock and power enable per active state.
// Assumes start is a level that is sampled only while idle.
module tcnn_ctrl
    import tcnn_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic            cap_en,
    output logic [NSTG-1:0] clk_en,
    output logic [NSTG-1:0] pwr_en,
    output logic            done
);

    state_t state, state_nx;

    // Next-state choice; every busy state lasts one cycle.
    always_comb begin
        case (state)
            S_IDLE:  state_nx = start ? S_QUANT : S_IDLE;
            S_QUANT: state_nx = S_CONV;
            S_CONV:  state_nx = S_POOL;
            S_POOL:  state_nx = S_FC;
            S_FC:    state_nx = S_DONE;
            default: state_nx = S_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // One enable bit per layer, high only in that layer's state.
    always_comb begin
        for (int s = 0; s < NSTG; s++) begin
            clk_en[s] = (state == state_t'(3'(s + 1)));
        end
    end

    assign pwr_en = clk_en;
    assign cap_en = start && (state == S_IDLE);
    assign done   = (state == S_DONE);

    // R7
    en_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clk_en) && (done -> (pwr_en == '0)));

    // R2
    fc_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FC) |=> done);

    // R1
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |=> !clk_en[0]);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && state == S_IDLE));

endmodule

// File: rtl/tcnn_feature.sv
// Feature stage: image capture, quantization and 4-filter valid convolution.
// Each register bank loads only on its own enable; sums saturate to 8 bits.
module tcnn_feature
    import tcnn_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cap_en,
    input  logic                      q_en,
    input  logic                      c_en,
    input  logic [NPIX-1:0]           img,
    output logic [NCONV-1:0][DW-1:0]  conv_q
);

    logic [NPIX-1:0]          img_q;
    logic [NPIX-1:0][DW-1:0]  quant_q;
    logic [NCONV-1:0][DW-1:0] conv_d;

    // Capture the image on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)      img_q <= '0;
        else if (cap_en) img_q <= img;
    end

    // Quantize every pixel to 0 or the positive full-scale value.
    always_ff @(posedge clk) begin
        if (!rst_n) quant_q <= '0;
        else if (q_en) begin
            for (int p = 0; p < NPIX; p++) quant_q[p] <= img_q[p] ? Q_ONE : '0;
        end
    end

    // Valid-only convolution with wide accumulation, then saturation.
    always_comb begin
        logic signed [ACC_W-1:0] acc;
        for (int f = 0; f < NFILT; f++) begin
            for (int r = 0; r < CONV_N; r++) begin
                for (int c = 0; c < CONV_N; c++) begin
                    acc = '0;
                    for (int kr = 0; kr < KER; kr++) begin
                        for (int kc = 0; kc < KER; kc++) begin
                            acc = acc + conv_w(f, kr, kc) *
                                  ACC_W'(signed'(quant_q[(r + kr) * IMG + c + kc]));
                        end
                    end
                    conv_d[(f * CONV_N + r) * CONV_N + c] = sat_px(acc);
                end
            end
        end
    end

    // Register the feature maps during the convolve cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    conv_q <= '0;
        else if (c_en) conv_q <= conv_d;
    end

    // R9
    quant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q_en |=> $stable(quant_q));

endmodule

// File: rtl/tcnn_pool.sv
// Pooling stage: signed max over non-overlapping 2x2 tiles of each map.
// Assumes the map side is even or drops the trailing row and column.
module tcnn_pool
    import tcnn_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic [NCONV-1:0][DW-1:0]  conv_q,
    output logic [NPOOL-1:0][DW-1:0]  pool_q
);

    logic [NPOOL-1:0][DW-1:0] pool_d;

    // Tile maxima, feature index f*9 + pr*3 + pc.
    always_comb begin
        for (int f = 0; f < NFILT; f++) begin
            for (int pr = 0; pr < POOL_N; pr++) begin
                for (int pc = 0; pc < POOL_N; pc++) begin
                    pool_d[(f * POOL_N + pr) * POOL_N + pc] = smax(
                        smax(conv_q[(f * CONV_N + 2 * pr) * CONV_N + 2 * pc],
                             conv_q[(f * CONV_N + 2 * pr) * CONV_N + 2 * pc + 1]),
                        smax(conv_q[(f * CONV_N + 2 * pr + 1) * CONV_N + 2 * pc],
                             conv_q[(f * CONV_N + 2 * pr + 1) * CONV_N + 2 * pc + 1]));
                end
            end
        end
    end

    // Register pooled features during the pool cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)  pool_q <= '0;
        else if (en) pool_q <= pool_d;
    end

    // R9
    pool_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(pool_q));

endmodule

// File: rtl/tcnn_fc.sv
// Scoring stage: one weighted sum per class, then argmax with ties to the lower index.
// Assumes pooled values fit the score width without overflow.
module tcnn_fc
    import tcnn_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic [NPOOL-1:0][DW-1:0]  pool_q,
    output logic [CLS_W-1:0]          cls_q
);

    logic [CLS_W-1:0] cls_d;

    // Class scores and strict-greater argmax.
    always_comb begin
        logic signed [SC_W-1:0] s;
        logic signed [SC_W-1:0] best;
        best  = '0;
        cls_d = '0;
        for (int k = 0; k < NCLS; k++) begin
            s = '0;
            for (int i = 0; i < NPOOL; i++) begin
                s = s + fc_w(k, i) * SC_W'(signed'(pool_q[i]));
            end
            if (k == 0 || s > best) begin
                best  = s;
                cls_d = CLS_W'(k);
            end
        end
    end

    // Register the winning class during the score cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)  cls_q <= '0;
        else if (en) cls_q <= cls_d;
    end

    // R9
    cls_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cls_q));

endmodule

// File: rtl/tiny_cnn_classifier.sv
// Top: controller plus feature, pool and scoring stages.
// The clock-enable bits double as the register load enables of each layer.
module tiny_cnn_classifier
    import tcnn_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [63:0]      img,
    output logic [3:0]       clk_en,
    output logic [3:0]       pwr_en,
    output logic             done,
    output logic [CLS_W-1:0] class_idx
);

    logic                     cap_en;
    logic [NCONV-1:0][DW-1:0] conv_q;
    logic [NPOOL-1:0][DW-1:0] pool_q;

    tcnn_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .cap_en(cap_en),
        .clk_en(clk_en), .pwr_en(pwr_en), .done(done)
    );

    tcnn_feature u_feature (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .q_en(clk_en[0]),
        .c_en(clk_en[1]), .img(img), .conv_q(conv_q)
    );

    tcnn_pool u_pool (
        .clk(clk), .rst_n(rst_n), .en(clk_en[2]), .conv_q(conv_q), .pool_q(pool_q)
    );

    tcnn_fc u_fc (
        .clk(clk), .rst_n(rst_n), .en(clk_en[3]), .pool_q(pool_q), .cls_q(class_idx)
    );

endmodule

// File: tb/tiny_cnn_classifier_bench.sv
// Bench: behavioural reference model stepped on every clock and compared at each falling edge.
module tiny_cnn_classifier_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] img = '0;
    logic [3:0]  clk_en, pwr_en;
    logic        done;
    logic        class_idx;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit cmp_on = 0;
    bit finished = 0;

    // reference model state
    int          m_state = 0;
    int          m_class = 0;
    logic [63:0] m_img = '0;

    tiny_cnn_classifier u_tiny_cnn_classifier (
        .clk(clk), .rst_n(rst_n), .start(start), .img(img),
        .clk_en(clk_en), .pwr_en(pwr_en), .done(done), .class_idx(class_idx)
    );

    always #4 clk = ~clk;

    function automatic int ref_class(logic [63:0] im);
        int q[8][8];
        int cv[4][6][6];
        int pl[36];
        int s0, s1, a, m;
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) q[r][c] = im[r*8+c] ? 127 : 0;   // R3
        for (int f = 0; f < 4; f++)
            for (int r = 0; r < 6; r++)
                for (int c = 0; c < 6; c++) begin
                    a = 0;
                    for (int kr = 0; kr < 3; kr++)
                        for (int kc = 0; kc < 3; kc++)
                            a += q[r+kr][c+kc] * (((f*9+kr*3+kc)*5+f) % 4 - 1);  // R4
                    if (a > 127) a = 127;
                    if (a < -128) a = -128;
                    cv[f][r][c] = a;
                end
        for (int f = 0; f < 4; f++)
            for (int pr = 0; pr < 3; pr++)
                for (int pc = 0; pc < 3; pc++) begin
                    m = cv[f][2*pr][2*pc];                                     // R5
                    if (cv[f][2*pr][2*pc+1] > m) m = cv[f][2*pr][2*pc+1];
                    if (cv[f][2*pr+1][2*pc] > m) m = cv[f][2*pr+1][2*pc];
                    if (cv[f][2*pr+1][2*pc+1] > m) m = cv[f][2*pr+1][2*pc+1];
                    pl[f*9+pr*3+pc] = m;
                end
        s0 = 0; s1 = 0;
        for (int i = 0; i < 36; i++) begin
            s0 += pl[i] * ((i*5) % 3 - 1);                                     // R6
            s1 += pl[i] * ((i*5+7) % 3 - 1);
        end
        return (s1 > s0) ? 1 : 0;
    endfunction

    // Step the model on each rising edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_state = 0; m_class = 0;
        end else begin
            case (m_state)
                0: if (start) begin m_img = img; m_state = 1; end
                4: begin m_class = ref_class(m_img); m_state = 5; end
                5: m_state = 0;
                default: m_state = m_state + 1;
            endcase
        end
    end

    // Compare outputs with the model at every falling edge.
    always @(negedge clk) begin
        logic [3:0] e_en;
        if (cmp_on && !finished) begin
            e_en = (m_state >= 1 && m_state <= 4) ? 4'(1 << (m_state - 1)) : 4'd0;
            checks++;
            if (clk_en !== e_en) begin
                errors++; $display("FAIL R7 R10 clk_en act=%b exp=%b", clk_en, e_en);
            end
            checks++;
            if (pwr_en !== e_en) begin
                errors++; $display("FAIL R7 R10 pwr_en act=%b exp=%b", pwr_en, e_en);
            end
            checks++;
            if (done !== (m_state == 5)) begin
                errors++; $display("FAIL R2 R8 done act=%b exp=%b", done, m_state == 5);
            end
            checks++;
            if (class_idx !== 1'(m_class)) begin
                errors++;
                $display("FAIL R3 R4 R5 R6 R9 class_idx act=%b exp=%0d", class_idx, m_class);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        if (cycles > 100000 && !finished) begin
            errors++;
            $display("FAIL watchdog act=%0d exp<=100000", cycles);
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Run one image; optionally disturb img and start while busy (R1). Counts cycles to done (R2).
    task automatic run_img(input logic [63:0] im, input bit disturb);
        int n;
        @(negedge clk); img = im; start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (disturb) img = ~im;
        n = 1;
        while (!done && n < 10) begin
            @(negedge clk);
            if (disturb && n == 1) begin start = 1'b1; img = im ^ 64'h00FF_00FF_00FF_00FF; end
            if (disturb && n == 2) start = 1'b0;
            n++;
        end
        checks++;
        if (n != 5) begin errors++; $display("FAIL R2 done latency act=%0d exp=5", n); end
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        logic [63:0] x;
        repeat (3) @(posedge clk);
        cmp_on = 1;
        @(negedge clk);
        // R10 reset state
        checks++;
        if (done !== 1'b0 || clk_en !== 4'd0 || class_idx !== 1'b0) begin
            errors++; $display("FAIL R10 reset act=%b/%b/%b exp=0/0/0", done, clk_en, class_idx);
        end
        @(negedge clk); rst_n = 1'b1;
        run_img(64'h0, 0);                     // R6 all-zero gives tie -> class 0
        run_img(64'hFFFF_FFFF_FFFF_FFFF, 0);   // R4 saturation
        run_img(64'hAA55_AA55_AA55_AA55, 1);   // R1 disturbance ignored
        run_img(64'hFF00_FF00_FF00_FF00, 0);
        run_img(64'hF0F0_F0F0_F0F0_F0F0, 1);
        run_img(64'h8040_2010_0804_0201, 0);
        // idle cycles: class must hold (R9)
        repeat (4) @(negedge clk);
        x = 64'h1234_5678_9ABC_DEF1;
        for (int t = 0; t < 40; t++) begin
            x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
            run_img(x, t[0]);
        end
        // back-to-back: start held across done
        @(negedge clk); img = 64'h0F0F_3C3C_F0F0_C3C3; start = 1'b1;
        repeat (12) @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        // R10 reset mid-run
        @(negedge clk); img = 64'hDEAD_BEEF_0123_4567; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        checks++;
        if (done !== 1'b0 || clk_en !== 4'd0 || class_idx !== 1'b0) begin
            errors++; $display("FAIL R10 mid-run reset act=%b/%b/%b exp=0/0/0",
                               done, clk_en, class_idx);
        end
        rst_n = 1'b1;
        run_img(64'hC3C3_C3C3_C3C3_C3C3, 0);
        repeat (3) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule